// File: doc/BRIEF.md
# Unsigned Integer to Single-Precision Float Converter

This block turns a small unsigned integer into a 32-bit IEEE 754 single-precision word. A gate-level leading-one finder reports where the most significant set bit sits. That single position is used twice. It is the unbiased exponent, and it also sets how far the value must move left so that the leading one lands in the implicit bit.

A logarithmic left shifter normalises the value. The exponent is then biased and the word is packed. The result is registered, so it appears exactly one clock after the input strobe.

Upstream logic presents a value together with a one-cycle strobe. Downstream logic takes the packed word whenever the output strobe is high. Between results the output word keeps its last value.

Top module: `u2f_conv`

## Requirements
- R1: Bit 31 of the output word is the sign and is always 0. Bits 30:23 hold the biased exponent. Bits 22:0 hold the fraction.
- R2: For a nonzero input whose highest set bit is at position p (bit 0 is the LSB), the exponent field equals p + 127.
- R3: The input bits below the leading one are placed at the top of the fraction field. Input bit p-1 goes to fraction bit 22, and so on downward. Every fraction bit below them is 0.
- R4: An all-zero input produces the all-zero word (+0.0).
- R5: `cvt_valid` is high in exactly the cycle after a cycle in which `in_valid` was high.
- R6: When `in_valid` is low, `cvt_word` keeps its previous value.
- R7: While `rst_n` is low, `cvt_valid` and `cvt_word` are both 0.
- R8: Sample points: input 1 gives 0x3F800000, input 150 gives 0x43160000, and input 255 gives 0x437F0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe qualifying `in_value` |
| in_value | input | IN_W (8) | Unsigned integer to convert |
| cvt_valid | output | 1 | High one cycle after an accepted input |
| cvt_word | output | 32 | Packed single-precision result |

## Verification
The assertions assume that `in_valid` and `in_value` are never unknown once reset is released. They also assume that `in_valid` is held low throughout reset, so the one-cycle latency check has a defined previous cycle. The bench drives inputs only on falling edges and keeps the strobe low during reset. It sweeps every input code, with irregular idle gaps in between, and these gaps also exercise the hold behaviour.

// File: rtl/u2f_pkg.sv
package u2f_pkg;
  localparam int FP_W      = 32;
  localparam int FP_EXP_W  = 8;
  localparam int FP_FRAC_W = 23;
  localparam int FP_BIAS   = 127;

  typedef struct packed {
    logic                 sign;
    logic [FP_EXP_W-1:0]  expo;
    logic [FP_FRAC_W-1:0] frac;
  } fp_word_t;

  // Biased exponent from an unbiased (non-negative) exponent.
  function automatic logic [FP_EXP_W-1:0] bias_exp(input logic [FP_EXP_W-1:0] unb);
    return unb + FP_EXP_W'(FP_BIAS);
  endfunction

  // Pack fields; a zero operand gives +0.0.
  function automatic fp_word_t pack_fp(input logic is_zero,
                                       input logic [FP_EXP_W-1:0] expo,
                                       input logic [FP_FRAC_W-1:0] frac);
    fp_word_t w;
    w.sign = 1'b0;
    w.expo = is_zero ? '0 : expo;
    w.frac = is_zero ? '0 : frac;
    return w;
  endfunction
endpackage

// File: rtl/u2f_lead_enc.sv
module u2f_lead_enc #(
  parameter int IN_W  = 8,
  parameter int POS_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  vec_i,
  output logic [POS_W-1:0] pos_o,
  output logic             any_o
);
  // mask_above[i]: some bit above i is set
  logic [IN_W-1:0] mask_above;
  logic [IN_W-1:0] hot;
  logic [POS_W-1:0][IN_W-1:0] sel;

  assign mask_above[IN_W-1] = 1'b0;
  genvar i, k;
  generate
    for (i = 0; i < IN_W-1; i++) begin : g_chain
      assign mask_above[i] = mask_above[i+1] | vec_i[i+1];
    end
    for (i = 0; i < IN_W; i++) begin : g_hot
      assign hot[i] = vec_i[i] & ~mask_above[i];
    end
    for (k = 0; k < POS_W; k++) begin : g_bit
      for (i = 0; i < IN_W; i++) begin : g_term
        if (((i >> k) % 2) == 1) begin : g_on
          assign sel[k][i] = hot[i];
        end else begin : g_off
          assign sel[k][i] = 1'b0;
        end
      end
      assign pos_o[k] = |sel[k];
    end
  endgenerate

  assign any_o = |vec_i;
endmodule

// File: rtl/u2f_norm.sv
module u2f_norm #(
  parameter int IN_W   = 8,
  parameter int POS_W  = $clog2(IN_W),
  parameter int FRAC_W = 23
) (
  input  logic [IN_W-1:0]   vec_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [FRAC_W-1:0] frac_o
);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(IN_W-1);
  localparam int PAD_W = FRAC_W - (IN_W-1);

  logic [POS_W-1:0] amt;
  logic [POS_W:0][IN_W-1:0] stg;

  assign amt    = TOP_POS - pos_i;
  assign stg[0] = vec_i;

  genvar s;
  generate
    for (s = 0; s < POS_W; s++) begin : g_stage
      assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
    end
  endgenerate

  // hidden bit at stg[POS_W][IN_W-1] is dropped
  assign frac_o = {stg[POS_W][IN_W-2:0], {PAD_W{1'b0}}};
endmodule

// File: rtl/u2f_conv.sv
module u2f_conv
  import u2f_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_value,
  output logic            cvt_valid,
  output logic [FP_W-1:0] cvt_word
);
  localparam int POS_W = $clog2(IN_W);

  logic [POS_W-1:0]     lead_pos;
  logic                 lead_any;
  logic [FP_FRAC_W-1:0] norm_frac;
  logic [FP_EXP_W-1:0]  exp_biased;
  logic                 load_en;
  fp_word_t             packed_w;

  u2f_lead_enc #(.IN_W(IN_W), .POS_W(POS_W)) u_enc (
    .vec_i(in_value), .pos_o(lead_pos), .any_o(lead_any)
  );

  u2f_norm #(.IN_W(IN_W), .POS_W(POS_W), .FRAC_W(FP_FRAC_W)) u_norm (
    .vec_i(in_value), .pos_i(lead_pos), .frac_o(norm_frac)
  );

  assign exp_biased = bias_exp(FP_EXP_W'(lead_pos));
  assign packed_w   = pack_fp(~lead_any, exp_biased, norm_frac);
  assign load_en    = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvt_valid <= 1'b0;
      cvt_word  <= '0;
    end else begin
      cvt_valid <= in_valid;
      if (load_en) cvt_word <= packed_w;
    end
  end

  // R2
  lead_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_any |-> (in_value[lead_pos] == 1'b1));
  // R2
  lead_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_any |-> ((in_value >> lead_pos) == IN_W'(1)));
  // R1
  sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_word[FP_W-1] == 1'b0);
  // R2
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_valid && cvt_word != '0) |->
      (cvt_word[30:23] >= 8'(FP_BIAS) && cvt_word[30:23] <= 8'(FP_BIAS + IN_W - 1)));
  // R3
  frac_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_valid |-> (cvt_word[FP_FRAC_W-IN_W:0] == '0));
  // R4
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_value == '0) |=> (cvt_word == '0));
  // R5
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_valid == $past(in_valid));
  // R6
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cvt_word));
endmodule

// File: tb/sim_u2f_conv.sv
module sim_u2f_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_value = '0;
  logic        cvt_valid;
  logic [31:0] cvt_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] last_word = '0;

  always #10 clk = ~clk;

  u2f_conv #(.IN_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .cvt_valid(cvt_valid), .cvt_word(cvt_word)
  );

  // Reference model: scan upward for the top set bit.
  function automatic logic [31:0] ref_fp(input int v);
    int msb = -1;
    logic [31:0] mant;
    if (v == 0) return 32'h0;
    for (int b = 0; b < 8; b++) if (v >= (1 << b)) msb = b;
    mant = 32'(v - (1 << msb)) << (23 - msb);
    return {1'b0, 8'(msb + 127), mant[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_value = 8'(v);
    exp_q.push_back(ref_fp(v));
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_value = 8'(j * 37 + 5);
    end
  endtask

  // Monitor: samples 5 ns after each rising edge.
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #5;
      if (cvt_valid) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected valid", 32'h1, 32'h0);
        end else begin
          last_word = exp_q.pop_front();
          // R1 R2 R3 R4 compared as one packed word
          check("R1/R2/R3/R4 word", cvt_word, last_word);
        end
      end else begin
        // R6 output held while idle
        check("R6 hold", cvt_word, last_word);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35;
    // R7 reset state
    check("R7 valid", {31'b0, cvt_valid}, 32'h0);
    check("R7 word", cvt_word, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 sample points
    send(1);   idle(1);
    send(150); idle(2);
    send(255); idle(1);
    // R4 zero after nonzero
    send(0);   idle(3);
    // R5 back-to-back full sweep with gaps
    for (int v = 0; v < 256; v++) begin
      send(v);
      if ((v % 7) == 3) idle(v % 4 + 1);
    end
    idle(3);
    // R8 explicit values
    send(150); idle(1);
    @(negedge clk);
    check("R8 150", cvt_word, 32'h43160000);
    send(1); idle(1);
    @(negedge clk);
    check("R8 1", cvt_word, 32'h3F800000);
    send(255); idle(1);
    @(negedge clk);
    check("R8 255", cvt_word, 32'h437F0000);
    idle(2);
    check("R5 queue drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule